// File: doc/BRIEF.md
# Custom Glyph Row and Cursor Generator

This block returns the five dots of one pixel row of a character cell. The caller supplies a character code, a row number, the font height and the display, cursor and blink enables, and says whether the cell is the one under the cursor. Codes with a zero upper nibble read a small writable glyph store. Every other code reads a stand-in pattern table that takes the place of the fixed character font. The block then places the cursor underline on the last row of the cell. While blinking is active it swaps the cursor cell for solid dots, using a timer that counts an external tick.

Software fills the glyph store through a plain address/data write port. The panel scanner drives the lookup inputs, and one clock later it reads the dot row from a registered output.

Top module: `glyph_row_gen`

## Requirements
- R1: While reset is asserted `dotRow` is 5'h00, and the blink phase starts at the normal (pattern) phase.
- R2: When `charCode[7:4]` is 0 the row comes from the glyph store. Otherwise the row comes from the stand-in table, whose value is `charCode[4:0] XOR {rowIdx[3:0],1'b0}`.
- R3: With `fontTall`=0 (5x7 cell, 8 rows), the store address is `{charCode[2:0], rowIdx[2:0]}` and `charCode[3]` has no effect.
- R4: With `fontTall`=1 (5x10 cell, 11 rows), the store address is `{charCode[2:1], rowIdx[3:0]}`, and `charCode[0]` and `charCode[3]` have no effect.
- R5: Stored bit 4 drives `dotRow[4]`, which is the leftmost dot, down to bit 0 driving `dotRow[0]`. A 1 lights the dot. A write to `wrAddr` with `wrEn`=1 stores the five bits of `wrData`.
- R6: When `dispOn` is 0, `dotRow` is 0. The stored glyphs are unchanged and show again once `dispOn` returns to 1.
- R7: When `cursorOn`=1 and `atCursor`=1, all five dots are ORed onto row 7 in 5x7 mode or onto row 10 in 5x10 mode. No other row is affected.
- R8: Rows beyond the cell height (8 to 15 in 5x7, 11 to 15 in 5x10) always give 0, even under cursor or blink.
- R9: While `blinkOn`=1 the blink phase toggles after every `BLINK_TICKS` cycles on which `tickEn` is high. In the fill phase, the visible rows of the cursor cell (`atCursor`=1) read 5'h1F. While `blinkOn`=0 the phase is held at normal and the tick count is cleared.
- R10: `dotRow` is registered. It reflects the inputs present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base tick counted by the blink timer |
| wrEn | input | 1 | Glyph store write strobe |
| wrAddr | input | 6 | Glyph store write address |
| wrData | input | 5 | Glyph dot bits to store |
| charCode | input | 8 | Character code of the cell |
| rowIdx | input | 4 | Pixel row within the cell |
| fontTall | input | 1 | 0: 5x7 cell, 1: 5x10 cell |
| dispOn | input | 1 | Display enable |
| cursorOn | input | 1 | Cursor underline enable |
| blinkOn | input | 1 | Cursor cell blink enable |
| atCursor | input | 1 | This cell is at the cursor position |
| dotRow | output | 5 | Dot row, bit 4 leftmost |

## Verification
A folding error in the address path makes a glyph show up under the wrong code or the wrong row. Every code and row is swept in both cell heights against a store whose contents are known, so such an error appears at the port one clock after the faulty lookup. A blink timer that counts wrong ticks or fails to clear moves the solid-fill phase by whole tick periods. Sampling the cursor cell after each tick exposes this within one blink interval. A cursor or display gate that is misplaced corrupts rows that should be dark or solid, and these are checked on every row.

// File: rtl/glyph_row_pkg.sv
package glyph_row_pkg;
  localparam int CODE_W      = 8;
  localparam int ROW_W       = 4;
  localparam int DOT_W       = 5;
  localparam int GLYPH_ADDR_W = 6;
  localparam int GLYPH_DEPTH = 1 << GLYPH_ADDR_W;
  localparam logic [ROW_W-1:0] LAST_ROW_SHORT = 4'd7;
  localparam logic [ROW_W-1:0] LAST_ROW_TALL  = 4'd10;

  // Strobes and decoded lookup fields from control to datapath
  typedef struct packed {
    logic                    ramWe;
    logic [GLYPH_ADDR_W-1:0] wrAddr;
    logic [GLYPH_ADDR_W-1:0] rdAddr;
    logic                    useRam;
    logic                    rowVisible;
    logic                    cursorHit;
    logic                    blinkFill;
  } glyphCtrl_t;
endpackage

// File: rtl/glyph_row_ctrl.sv
module glyph_row_ctrl
  import glyph_row_pkg::*;
#(
  parameter int BLINK_TICKS = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickEn,
  input  logic                    blinkOn,
  input  logic                    wrEn,
  input  logic [GLYPH_ADDR_W-1:0] wrAddr,
  input  logic [3:0]              codeHigh,
  input  logic [2:0]              codeLow,
  input  logic [ROW_W-1:0]        rowIdx,
  input  logic                    fontTall,
  input  logic                    dispOn,
  input  logic                    cursorOn,
  input  logic                    atCursor,
  output glyphCtrl_t              ctrl
);
  localparam int CNT_W = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_TICKS - 1);

  logic [CNT_W-1:0] blinkCnt;
  logic             blinkPhase;
  logic [ROW_W-1:0] lastRow;

  // Blink time base: counts ticks, flips the phase every BLINK_TICKS ticks
  always_ff @(posedge clk) begin
    if (!rstN || !blinkOn) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else if (tickEn) begin
      if (blinkCnt == CNT_LAST) begin
        blinkCnt   <= '0;
        blinkPhase <= ~blinkPhase;
      end else begin
        blinkCnt <= blinkCnt + 1'b1;
      end
    end
  end

  always_comb begin
    lastRow         = fontTall ? LAST_ROW_TALL : LAST_ROW_SHORT;
    ctrl.ramWe      = wrEn;
    ctrl.wrAddr     = wrAddr;
    ctrl.useRam     = (codeHigh == 4'd0);
    ctrl.rdAddr     = fontTall ? {codeLow[2:1], rowIdx}
                               : {codeLow, rowIdx[2:0]};
    ctrl.rowVisible = dispOn && (rowIdx <= lastRow);
    ctrl.cursorHit  = cursorOn && atCursor && (rowIdx == lastRow);
    ctrl.blinkFill  = blinkOn && atCursor && blinkPhase;
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    blinkCnt <= CNT_LAST);
  a_r9_phase_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !blinkOn |=> !blinkPhase);
  a_r9_phase_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (blinkOn && !tickEn) |=> $stable(blinkPhase));
endmodule

// File: rtl/glyph_row_dp.sv
module glyph_row_dp
  import glyph_row_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  glyphCtrl_t        ctrl,
  input  logic [DOT_W-1:0]  wrData,
  input  logic [DOT_W-1:0]  romCode,
  input  logic [ROW_W-1:0]  rowIdx,
  output logic [DOT_W-1:0]  dotRow
);
  logic [DOT_W-1:0] glyphMem [GLYPH_DEPTH];
  logic [DOT_W-1:0] ramDots;
  logic [DOT_W-1:0] romDots;
  logic [DOT_W-1:0] baseDots;
  logic [DOT_W-1:0] rowShift;
  logic [DOT_W-1:0] dotNext;

  // Glyph store: only the displayable bits are kept
  always_ff @(posedge clk) begin
    if (ctrl.ramWe) glyphMem[ctrl.wrAddr] <= wrData;
  end

  assign ramDots  = glyphMem[ctrl.rdAddr];
  assign rowShift = {rowIdx, 1'b0};
  assign baseDots = ctrl.useRam ? ramDots : romDots;

  // Per-dot stand-in pattern and overlay
  for (genvar p = 0; p < DOT_W; p++) begin : g_dot
    assign romDots[p] = romCode[p] ^ rowShift[p];
    assign dotNext[p] = ctrl.rowVisible &
                        (ctrl.blinkFill | ctrl.cursorHit | baseDots[p]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) dotRow <= '0;
    else       dotRow <= dotNext;
  end

  a_r8_dark_when_hidden: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.rowVisible |=> (dotRow == '0));
  a_r7_cursor_solid: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rowVisible && ctrl.cursorHit) |=> (dotRow == '1));
endmodule

// File: rtl/glyph_row_gen.sv
module glyph_row_gen
  import glyph_row_pkg::*;
#(
  parameter int BLINK_TICKS = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic [5:0]  wrAddr,
  input  logic [4:0]  wrData,
  input  logic [7:0]  charCode,
  input  logic [3:0]  rowIdx,
  input  logic        fontTall,
  input  logic        dispOn,
  input  logic        cursorOn,
  input  logic        blinkOn,
  input  logic        atCursor,
  output logic [4:0]  dotRow
);
  glyphCtrl_t ctrl;

  glyph_row_ctrl #(.BLINK_TICKS(BLINK_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .blinkOn(blinkOn),
    .wrEn(wrEn), .wrAddr(wrAddr), .codeHigh(charCode[7:4]),
    .codeLow(charCode[2:0]), .rowIdx(rowIdx), .fontTall(fontTall),
    .dispOn(dispOn), .cursorOn(cursorOn), .atCursor(atCursor), .ctrl(ctrl)
  );

  glyph_row_dp dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData),
    .romCode(charCode[4:0]), .rowIdx(rowIdx), .dotRow(dotRow)
  );

  // Port-level checks
  a_r6_display_dark: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |=> (dotRow == 5'h00));
  a_r8_short_rows: assert property (@(posedge clk) disable iff (!rstN)
    (!fontTall && rowIdx > 4'd7) |=> (dotRow == 5'h00));
  a_r8_tall_rows: assert property (@(posedge clk) disable iff (!rstN)
    (fontTall && rowIdx > 4'd10) |=> (dotRow == 5'h00));
  a_r7_cursor_row: assert property (@(posedge clk) disable iff (!rstN)
    (dispOn && cursorOn && atCursor &&
     ((!fontTall && rowIdx == 4'd7) || (fontTall && rowIdx == 4'd10)))
    |=> (dotRow == 5'h1F));
endmodule

// File: tb/glyph_row_gen_tb.sv
module glyph_row_gen_tb_top;
  localparam int TICKS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [4:0] wrData = '0;
  logic [7:0] charCode = '0;
  logic [3:0] rowIdx = '0;
  logic fontTall = 1'b0, dispOn = 1'b1, cursorOn = 1'b0, blinkOn = 1'b0, atCursor = 1'b0;
  logic [4:0] dotRow;

  int nRun = 0, nFail = 0;
  logic [4:0] shadow [64];

  always #10 clk = ~clk;

  glyph_row_gen #(.BLINK_TICKS(TICKS)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .charCode(charCode), .rowIdx(rowIdx), .fontTall(fontTall),
    .dispOn(dispOn), .cursorOn(cursorOn), .blinkOn(blinkOn), .atCursor(atCursor),
    .dotRow(dotRow)
  );

  function automatic logic [4:0] fillPat(int a);
    return 5'((a * 37 + 11) ^ (a >> 2));
  endfunction

  function automatic logic [4:0] expRow(logic [7:0] c, logic [3:0] r, logic tall,
                                        logic dOn, logic cOn, logic bOn, logic at,
                                        logic phase);
    int last;
    logic [4:0] v;
    int addr;
    last = tall ? 10 : 7;
    if (!dOn || int'(r) > last) return 5'h00;
    if (bOn && at && phase) return 5'h1F;
    if (c[7:4] == 4'd0) begin
      addr = tall ? (int'(c[2:1]) * 16 + int'(r)) : (int'(c[2:0]) * 8 + int'(r[2:0]));
      v = shadow[addr];
    end else begin
      v = c[4:0] ^ {r, 1'b0};
    end
    if (cOn && at && int'(r) == last) v = 5'h1F;
    return v;
  endfunction

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s code=%h row=%0d tall=%0b act=%h exp=%h",
               req, charCode, rowIdx, fontTall, act, exp);
    end
  endtask

  task automatic probe(string req, logic [7:0] c, logic [3:0] r, logic phase);
    charCode = c;
    rowIdx   = r;
    cycle();
    chk(req, dotRow, expRow(c, r, fontTall, dispOn, cursorOn, blinkOn, atCursor, phase));
  endtask

  initial begin
    #3000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset", dotRow, 5'h00);
    rstN = 1'b1;

    // R5: fill glyph store
    for (int a = 0; a < 64; a++) begin
      wrEn = 1'b1; wrAddr = 6'(a); wrData = fillPat(a); shadow[a] = fillPat(a);
      cycle();
    end
    wrEn = 1'b0;

    // R10: output holds until the next edge
    charCode = 8'h41; rowIdx = 4'd2; cycle();
    charCode = 8'h03; rowIdx = 4'd5;
    #1;
    chk("R10 latency hold", dotRow, expRow(8'h41, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    cycle();
    chk("R10 latency update", dotRow, expRow(8'h03, 4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));

    // R2 R3 R4 R5 R8: full sweep of codes and rows, both heights
    for (int t = 0; t < 2; t++) begin
      fontTall = 1'(t);
      for (int c = 0; c < 256; c++)
        for (int r = 0; r < 16; r++)
          probe(c < 16 ? (t == 0 ? "R2 R3 R5 R8" : "R2 R4 R5 R8") : "R2 R8",
                8'(c), 4'(r), 1'b0);
    end

    // R7: cursor overlay, on and off the cursor cell
    cursorOn = 1'b1;
    for (int t = 0; t < 2; t++) begin
      fontTall = 1'(t);
      for (int at = 0; at < 2; at++) begin
        atCursor = 1'(at);
        for (int c = 0; c < 32; c++)
          for (int r = 0; r < 16; r++)
            probe("R7 R8", 8'(c), 4'(r), 1'b0);
      end
    end
    cursorOn = 1'b0; atCursor = 1'b0;

    // R6: display off blanks everything, store survives
    dispOn = 1'b0; fontTall = 1'b0;
    for (int c = 0; c < 16; c++) probe("R6 off", 8'(c), 4'(c), 1'b0);
    dispOn = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) probe("R6 restore", 8'(c), 4'(r), 1'b0);

    // R9: blink timing
    fontTall = 1'b0; atCursor = 1'b1; blinkOn = 1'b1;
    probe("R9 start normal", 8'h02, 4'd3, 1'b0);
    for (int k = 0; k < TICKS - 1; k++) begin
      tickEn = 1'b1; cycle(); tickEn = 1'b0;
      probe("R9 before period", 8'h02, 4'd3, 1'b0);
    end
    tickEn = 1'b1; cycle(); tickEn = 1'b0;
    probe("R9 fill phase", 8'h02, 4'd3, 1'b1);
    probe("R9 fill ROM code", 8'h5A, 4'd0, 1'b1);
    probe("R8 fill hidden row", 8'h02, 4'd9, 1'b1);
    atCursor = 1'b0;
    probe("R9 non-cursor cell", 8'h02, 4'd3, 1'b1);
    atCursor = 1'b1;
    repeat (5) probe("R9 no tick holds", 8'h02, 4'd4, 1'b1);
    for (int k = 0; k < TICKS; k++) begin
      tickEn = 1'b1; cycle(); tickEn = 1'b0;
      if (k < TICKS - 1) probe("R9 fill held", 8'h02, 4'd3, 1'b1);
    end
    probe("R9 back to normal", 8'h02, 4'd3, 1'b0);
    // advance to fill, then disable: must restart at normal with cleared count
    for (int k = 0; k < TICKS; k++) begin
      tickEn = 1'b1; cycle(); tickEn = 1'b0;
    end
    probe("R9 fill again", 8'h06, 4'd1, 1'b1);
    blinkOn = 1'b0;
    probe("R9 disabled normal", 8'h06, 4'd1, 1'b0);
    blinkOn = 1'b1;
    probe("R9 reenable normal", 8'h06, 4'd1, 1'b0);
    for (int k = 0; k < TICKS - 1; k++) begin
      tickEn = 1'b1; cycle(); tickEn = 1'b0;
    end
    probe("R9 count was cleared", 8'h06, 4'd1, 1'b0);
    blinkOn = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule